// File: doc/BRIEF.md
# Cartridge ROM/RAM Bank Controller

This block sits beside the cartridge connector of an 8-bit CPU system and snoops CPU writes into the ROM address space. Such writes never reach the ROM. The block decodes them into a small set of bank registers and drives two outputs: the bank number of the switchable 16 KiB ROM window and the bank number of the external RAM. Read paths, the storage arrays and RAM enabling belong to other blocks, which consume these bank numbers.

The top three address bits pick the register. Region `3'b001` loads the five low bits of the ROM bank. Region `3'b010` loads a 2-bit secondary value, and the banking mode decides where it goes. In mode 0 it becomes ROM bank bits 6:5. In mode 1 it becomes the RAM bank. Region `3'b011` sets the mode, and each mode write also rewrites the bank outputs.

The ROM size is a power-of-two parameter. When a requested bank lies past the end of the ROM, the block keeps only the bank bits that fit the ROM, so the bank wraps around. It also raises a one-cycle flag.

Top module: `cart_bank_ctrl`

## Requirements
- R1: After reset the ROM bank is 1, the RAM bank is 0, the mode is 0 and the invalid-bank flag is 0.
- R2: A write with address bits 15:13 = `3'b001` requests ROM bank {current bank bits 6:5, data bits 4:0}.
- R3: A write with address bits 15:13 = `3'b010` in mode 0 requests ROM bank {data bits 1:0, current bank bits 4:0}, and the RAM bank is unchanged.
- R4: A write with address bits 15:13 = `3'b010` in mode 1 sets the RAM bank to data bits 1:0, and the ROM bank is unchanged.
- R5: A write with address bits 15:13 = `3'b011` sets the mode to data bit 0.
- R6: A mode write with data bit 0 = 1 requests ROM bank {2'b00, current bank bits 4:0}. The RAM bank is unchanged.
- R7: A mode write with data bit 0 = 0 forces the RAM bank to 0, and the ROM bank is unchanged.
- R8: Every requested bank is stored as (requested mod number of banks), where the number of banks is ROM_KIB/16. The ROM bank output is therefore always below the number of banks.
- R9: The invalid-bank flag is 1 for exactly the cycle after a bank request that is at or above the number of banks. In every other cycle it is 0.
- R10: With the write strobe low, or with address bits 15:13 = `3'b000` or address bit 15 = 1, no output changes and the flag stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | CPU write strobe, one write per cycle it is high |
| addr | input | 16 | CPU write address |
| wdata | input | 8 | CPU write data |
| rom_bank | output | 7 | Effective bank of the switchable ROM window |
| ram_bank | output | 2 | External RAM bank |
| mode | output | 1 | Banking mode |
| bank_bad | output | 1 | One-cycle flag: the last request was past the ROM end |

## Verification
The bench runs the block with a 64-bank ROM. At that size bank bit 5 survives wrapping and bit 6 does not. An upper write of 3 therefore has to wrap and flag. A design that masked the wrong bits, or flagged without wrapping, would show a bank of 64 or more, or a missing pulse.

A low-bank write that follows a wrapped upper write checks that the preserved bits 6:5 come from the effective bank, not from the raw request. Repeated mode writes check two things. Re-entering mode 1 must clear the high bank bits and leave the RAM bank alone. Entering mode 0 must zero the RAM bank without moving the ROM bank.

Writes to the unused regions, writes with the strobe low, and upper writes in mode 1 are compared every cycle. Any leakage from those writes into the ROM bank would show at once as a miscompare.

// File: rtl/cbc_pkg.sv
package cbc_pkg;

    localparam int unsigned REQ_W = 7;
    localparam int unsigned RAM_W = 2;
    localparam int unsigned LOW_W = 5;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_LOW,
        REG_HIGH,
        REG_MODE
    } cbc_reg_e;

    typedef struct packed {
        logic [REQ_W-1:0] rom;
        logic [RAM_W-1:0] ram;
        logic             mode;
        logic             bad;
    } cbc_state_t;

endpackage

// File: rtl/cbc_decode.sv
module cbc_decode
    import cbc_pkg::*;
#(
    parameter int unsigned ADDR_W = 16
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    output cbc_reg_e          sel
);

    localparam int unsigned TOP = ADDR_W - 1;

    logic [2:0] region;
    logic       unused_low_addr;

    assign region          = addr[TOP -: 3];
    assign unused_low_addr = ^addr[TOP-3:0];

    always_comb begin
        sel = REG_NONE;
        if (wr_en) begin
            case (region)
                3'b001:  sel = REG_LOW;
                3'b010:  sel = REG_HIGH;
                3'b011:  sel = REG_MODE;
                default: sel = REG_NONE;
            endcase
        end
    end

endmodule

// File: rtl/cbc_wrap.sv
module cbc_wrap
    import cbc_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 128
) (
    input  logic [REQ_W-1:0] req,
    output logic [REQ_W-1:0] eff,
    output logic             over
);

    localparam int unsigned MAX_REQ = 1 << REQ_W;
    localparam int unsigned MASK_I  = (NUM_BANKS >= MAX_REQ) ? (MAX_REQ - 1) : (NUM_BANKS - 1);
    localparam logic [REQ_W-1:0] MASK = MASK_I[REQ_W-1:0];

    assign eff  = req & MASK;
    assign over = (32'(req) >= NUM_BANKS);

endmodule

// File: rtl/cart_bank_ctrl.sv
module cart_bank_ctrl
    import cbc_pkg::*;
#(
    parameter int unsigned ROM_KIB = 2048,
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DATA_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [REQ_W-1:0]  rom_bank,
    output logic [RAM_W-1:0]  ram_bank,
    output logic              mode,
    output logic              bank_bad
);

    localparam int unsigned BANK_KIB  = 16;
    localparam int unsigned NUM_BANKS = ROM_KIB / BANK_KIB;

    generate
        if (ROM_KIB < 32 || (ROM_KIB & (ROM_KIB - 1)) != 0) begin : g_bad_size
            $error("ROM_KIB must be a power of two of at least 32");
        end
    endgenerate

    cbc_state_t       state_q, state_d;
    cbc_reg_e         sel;
    logic [REQ_W-1:0] req, eff;
    logic             upd, over;
    logic             unused_data;

    assign unused_data = ^wdata[DATA_W-1:LOW_W];

    cbc_decode #(.ADDR_W(ADDR_W)) u_decode (
        .wr_en (wr_en),
        .addr  (addr),
        .sel   (sel)
    );

    cbc_wrap #(.NUM_BANKS(NUM_BANKS)) u_wrap (
        .req  (req),
        .eff  (eff),
        .over (over)
    );

    // Requested bank from the register being written
    always_comb begin
        req = state_q.rom;
        upd = 1'b0;
        case (sel)
            REG_LOW: begin
                req = {state_q.rom[REQ_W-1:LOW_W], wdata[LOW_W-1:0]};
                upd = 1'b1;
            end
            REG_HIGH: begin
                if (!state_q.mode) begin
                    req = {wdata[RAM_W-1:0], state_q.rom[LOW_W-1:0]};
                    upd = 1'b1;
                end
            end
            REG_MODE: begin
                if (wdata[0]) begin
                    req = {{(REQ_W-LOW_W){1'b0}}, state_q.rom[LOW_W-1:0]};
                    upd = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Next state
    always_comb begin
        state_d     = state_q;
        state_d.bad = 1'b0;
        if (upd) begin
            state_d.rom = eff;
            state_d.bad = over;
        end
        case (sel)
            REG_HIGH: begin
                if (state_q.mode) state_d.ram = wdata[RAM_W-1:0];
            end
            REG_MODE: begin
                state_d.mode = wdata[0];
                if (!wdata[0]) state_d.ram = '0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.rom  <= REQ_W'(1);
            state_q.ram  <= '0;
            state_q.mode <= 1'b0;
            state_q.bad  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rom_bank = state_q.rom;
    assign ram_bank = state_q.ram;
    assign mode     = state_q.mode;
    assign bank_bad = state_q.bad;

    // Checks
    assert_bank_in_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        32'(rom_bank) < NUM_BANKS);

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(rom_bank) && $stable(ram_bank) && $stable(mode) && !bank_bad));

    assert_high_keeps_ram_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REG_HIGH && !mode) |=> $stable(ram_bank));

    assert_high_keeps_rom_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REG_HIGH && mode) |=> ($stable(rom_bank) && !bank_bad));

    assert_mode_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REG_MODE) |=> (mode == $past(wdata[0])));

    assert_mode0_clears_ram_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == REG_MODE && !wdata[0]) |=> (ram_bank == '0 && $stable(rom_bank)));

endmodule

// File: tb/sim_cart_bank_ctrl.sv
`timescale 1ns/1ps
module sim_cart_bank_ctrl;

    localparam int ROM_KIB = 1024;
    localparam int BANKS   = ROM_KIB / 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [6:0]  rom_bank;
    logic [1:0]  ram_bank;
    logic        mode;
    logic        bank_bad;

    int vectors = 0;
    int miscompares = 0;
    bit done = 0;

    int m_rom = 1, m_ram = 0, m_mode = 0, m_bad = 0;

    always #5 clk = ~clk;

    cart_bank_ctrl #(.ROM_KIB(ROM_KIB)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rom_bank(rom_bank), .ram_bank(ram_bank), .mode(mode), .bank_bad(bank_bad)
    );

    task automatic compare(input string tag);
        bit bad = 0;
        vectors++;
        if (int'(rom_bank) != m_rom) begin
            bad = 1;
            $display("FAIL %s rom_bank actual %0d expected %0d", tag, rom_bank, m_rom);
        end
        if (int'(ram_bank) != m_ram) begin
            bad = 1;
            $display("FAIL %s ram_bank actual %0d expected %0d", tag, ram_bank, m_ram);
        end
        if (int'(mode) != m_mode) begin
            bad = 1;
            $display("FAIL %s mode actual %0d expected %0d", tag, mode, m_mode);
        end
        if (int'(bank_bad) != m_bad) begin
            bad = 1;
            $display("FAIL %s (flag R9) bank_bad actual %0d expected %0d", tag, bank_bad, m_bad);
        end
        if (bad) miscompares++;
    endtask

    // Drive one cycle at a negedge, update model, compare at next negedge
    task automatic step(input bit we, input int a, input int d, input string tag);
        int region;
        int req;
        wr_en = we;
        addr  = 16'(a);
        wdata = 8'(d);
        region = (a % 65536) / 8192;
        req = -1;
        m_bad = 0;
        if (we) begin
            case (region)
                1: req = ((m_rom / 32) % 4) * 32 + (d % 32);
                2: if (m_mode == 0) req = (d % 4) * 32 + (m_rom % 32);
                   else m_ram = d % 4;
                3: begin
                    if (d % 2 == 1) req = m_rom % 32;
                    else m_ram = 0;
                    m_mode = d % 2;
                end
                default: ;
            endcase
        end
        if (req >= 0) begin
            m_rom = req % BANKS;
            m_bad = (req >= BANKS) ? 1 : 0;
        end
        @(negedge clk);
        compare(tag);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        compare("R1");

        step(1, 16'h2000, 8'h05, "R2");   // bank 5
        step(1, 16'h4000, 8'h01, "R3");   // 37
        step(1, 16'h5123, 8'h03, "R8");   // 101 -> 37, flag
        step(1, 16'h3FFF, 8'hFF, "R2");   // {01,11111} = 63
        step(0, 16'h4000, 8'h02, "R10");  // strobe low
        step(1, 16'h6000, 8'h01, "R6");   // mode 1 -> 31
        step(1, 16'h4000, 8'h02, "R4");   // ram 2, rom kept
        step(1, 16'h0000, 8'hFF, "R10");  // region 0
        step(1, 16'hA000, 8'h1F, "R10");  // RAM space
        step(1, 16'h7FFF, 8'h01, "R6");   // mode 1 again, ram kept
        step(1, 16'h6000, 8'h00, "R7");   // mode 0, ram 0
        step(1, 16'h4000, 8'h02, "R3");   // {10,11111}=95 -> 31, flag
        step(1, 16'h2000, 8'h00, "R2");   // bank 0
        step(1, 16'h4000, 8'h01, "R5");
        step(1, 16'h6000, 8'h03, "R5");   // mode 1 via bit0 of 3

        for (int i = 0; i < 400; i++) begin
            int k;
            int a;
            int d;
            k = int'($urandom % 8);
            d = int'($urandom % 256);
            a = int'($urandom % 8192);
            case (k)
                0, 1: step(1, 8192 + a, d, "R2");
                2, 3: step(1, 16384 + a, d, "R3");
                4:    step(1, 24576 + a, d, "R5");
                5:    step(0, 16384 + a, d, "R10");
                6:    step(1, a, d, "R10");
                default: step(1, 32768 + int'($urandom % 32768), d, "R10");
            endcase
        end

        wr_en = 1'b0;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            miscompares++;
            $display("FAIL watchdog expired actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule